// File: doc/BRIEF.md
# SPI-mode memory-card command engine

This block issues a single memory-card command over a byte-serial SPI master and collects the card's reply. The host supplies a 6-bit opcode, a 32-bit argument and a reply format, then pulses `start`. The engine clocks out a fixed eight-byte frame: a filler byte, the command, the argument, a check byte and a closing filler. It then keeps clocking filler bytes until the card returns a byte with its top bit clear. Any further reply bytes that the format calls for are gathered next, and the engine reports success, a timeout or an I/O error on a two-bit status together with a one-cycle `done` pulse.

A second request, raised with `init` together with `start`, runs the card wake-up sequence. A fixed number of all-ones bytes are clocked with chip-select released (high), and chip-select is then driven low and held low for the commands that follow. Each command picks its own clock divider: the wake-up sequence and the reset opcode use the slow setting, and every other command uses the medium one. Data-block transfers and check-byte computation for general commands are left to other logic.

Top module: `spicmd_engine`

## Requirements
- R1: A command sends, in this order, 0xFF, 0x40 ORed with the opcode, the argument bytes from bit 31 down to bit 0, the check byte and a final 0xFF. Chip-select is low for the whole command.
- R2: The check byte is 0x95 for opcode 0, 0x87 for opcode 8 and 0x00 for every other opcode.
- R3: One SPI bit lasts divider+1 base clock cycles. The divider is SLOW_DIV for opcode 0 and for the wake-up sequence, and MED_DIV for all other opcodes.
- R4: After the frame, the engine reads bytes, transmitting 0xFF (MOSI high) while it does so, until a byte has bit 7 clear. Bytes received during the frame are ignored.
- R5: If POLL_LIMIT reads in a row all have bit 7 set, the command ends with status 1 (timeout) after exactly 8+POLL_LIMIT bytes. A reply found on read number POLL_LIMIT is still accepted.
- R6: With `rsp_type`=1, one more byte is read and `resp` = {second byte, first byte}. With `rsp_type` 0 or 3, `resp` = {0x00, first byte}.
- R7: With `rsp_type`=2, four more bytes are read and `resp_ext` holds them with the first one received in bits 31:24.
- R8: The status is 0 (ok) when the first reply byte is 0x00 or 0x01, and 2 (I/O error) for any other first byte. The value 3 is never reported.
- R9: A wake-up request sends INIT_BYTES bytes of 0xFF with chip-select high, then drives chip-select low and reports status 0.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse seen with `busy` low. A `start` raised while busy is ignored.
- R11: After reset, `busy` and `done` are 0, `status` is 0, chip-select is high, SCLK is low and MOSI is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command or, together with init, the wake-up sequence |
| init | input | 1 | Select the wake-up sequence on start |
| opcode | input | 6 | Command opcode |
| arg | input | 32 | Command argument |
| rsp_type | input | 2 | Reply format: 0 one byte, 1 two bytes, 2 one plus four bytes |
| busy | output | 1 | Engine is working |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 I/O error |
| resp | output | 16 | First reply byte in bits 7:0, second byte in bits 15:8 |
| resp_ext | output | 32 | Four extra reply bytes, first received in bits 31:24 |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the card |
| miso | input | 1 | SPI data from the card |
| cs_n | output | 1 | Card chip-select, active low |

## Verification
The bench sweeps all 64 opcodes and checks the frame and check byte each time. A framer that swapped argument bytes or misplaced a check value would show up on the wrong opcode. It then sweeps all 128 first-byte values with bit 7 clear, which exposes a success test that accepts more than 0x00 and 0x01. The timeout boundary is tested one read on each side of POLL_LIMIT, so an off-by-one poll counter either reports a reply as a timeout or clocks one byte too many. The bench also measures the SCLK bit period per command to catch a divider chosen from the wrong opcode, counts wake-up bytes sent with chip-select high, and raises a second `start` mid-command that must not restart the frame.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_TIMEOUT = 2'd1,
      ST_IOERR   = 2'd2
   } cmd_status_e;

   typedef enum logic [1:0] {
      RT_SHORT = 2'd0,
      RT_WIDE  = 2'd1,
      RT_LONG  = 2'd2
   } rsp_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAKE,
      S_FRAME,
      S_POLL,
      S_EXTRA
   } eng_state_e;

   localparam logic [5:0] OP_RESET = 6'd0;
   localparam logic [5:0] OP_IFCOND = 6'd8;

   function automatic logic [7:0] check_byte(input logic [5:0] op);
      if (op == OP_RESET)
         return 8'h95;
      else if (op == OP_IFCOND)
         return 8'h87;
      else
         return 8'h00;
   endfunction

   function automatic logic reply_ok(input logic [7:0] b);
      return (b == 8'h00) || (b == 8'h01);
   endfunction

endpackage

// File: rtl/spicmd_shifter.sv
module spicmd_shifter #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [7:0]       tx,
   input  logic [DIV_W-1:0] div,
   output logic             active,
   output logic             done,
   output logic [7:0]       rx,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] half;
   logic [2:0]       bitn;
   logic [7:0]       sh_tx;
   logic [7:0]       sh_rx;

   assign half = div_q >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         cnt    <= '0;
         div_q  <= '0;
         bitn   <= '0;
         sh_tx  <= 8'hFF;
         sh_rx  <= 8'h00;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               cnt    <= '0;
               bitn   <= '0;
               div_q  <= div;
               sh_tx  <= tx;
            end
         end else begin
            if (cnt == half)
               sh_rx <= {sh_rx[6:0], miso};
            if (cnt == div_q) begin
               cnt   <= '0;
               sh_tx <= {sh_tx[6:0], 1'b1};
               bitn  <= bitn + 3'd1;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign rx   = sh_rx;
   assign sclk = active && (cnt > half);
   assign mosi = active ? sh_tx[7] : 1'b1;

   // R3: the phase counter never passes the latched divider
   a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= div_q));

   // R3: the divider is held for the whole byte
   a_r3_div_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(div_q));

   // R11: no clock edges while idle
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!sclk && mosi));

endmodule

// File: rtl/spicmd_framer.sv
module spicmd_framer
   import spicmd_pkg::*;
(
   input  logic [5:0]  opcode,
   input  logic [31:0] arg,
   input  logic [2:0]  idx,
   output logic [7:0]  byte_o
);

   logic [7:0] arg_b [4];

   for (genvar g = 0; g < 4; g++) begin : g_argb
      assign arg_b[g] = arg[31-8*g -: 8];
   end

   always_comb begin
      unique case (idx)
         3'd0:    byte_o = 8'hFF;
         3'd1:    byte_o = {2'b01, opcode};
         3'd2:    byte_o = arg_b[0];
         3'd3:    byte_o = arg_b[1];
         3'd4:    byte_o = arg_b[2];
         3'd5:    byte_o = arg_b[3];
         3'd6:    byte_o = check_byte(opcode);
         default: byte_o = 8'hFF;
      endcase
   end

endmodule

// File: rtl/spicmd_engine.sv
module spicmd_engine
   import spicmd_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int SLOW_DIV   = 144,
   parameter int MED_DIV    = 48,
   parameter int POLL_LIMIT = 1000,
   parameter int INIT_BYTES = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        init,
   input  logic [5:0]  opcode,
   input  logic [31:0] arg,
   input  logic [1:0]  rsp_type,
   output logic        busy,
   output logic        done,
   output logic [1:0]  status,
   output logic [15:0] resp,
   output logic [31:0] resp_ext,
   output logic        sclk,
   output logic        mosi,
   input  logic        miso,
   output logic        cs_n
);

   localparam int PC_W  = $clog2(POLL_LIMIT + 1);
   localparam int IC_W0 = $clog2(INIT_BYTES + 1);
   localparam int IC_W  = (IC_W0 < 3) ? 3 : IC_W0;
   localparam logic [DIV_W-1:0] DIV_SLOW = DIV_W'(SLOW_DIV);
   localparam logic [DIV_W-1:0] DIV_MED  = DIV_W'(MED_DIV);
   localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(POLL_LIMIT - 1);
   localparam logic [IC_W-1:0]  WAKE_LAST = IC_W'(INIT_BYTES - 1);

   if (SLOW_DIV < 1 || SLOW_DIV >= (1 << DIV_W)) begin : g_bad_slow
      $error("SLOW_DIV out of range for DIV_W");
   end
   if (MED_DIV < 1 || MED_DIV >= (1 << DIV_W)) begin : g_bad_med
      $error("MED_DIV out of range for DIV_W");
   end
   if (POLL_LIMIT < 1) begin : g_bad_poll
      $error("POLL_LIMIT must be at least 1");
   end
   if (INIT_BYTES < 1) begin : g_bad_init
      $error("INIT_BYTES must be at least 1");
   end

   eng_state_e       st;
   logic [IC_W-1:0]  idx;
   logic [PC_W-1:0]  poll_cnt;
   logic [2:0]       ext_left;
   logic [5:0]       op_q;
   logic [31:0]      arg_q;
   logic [1:0]       typ_q;

   logic             sh_go, sh_active, sh_done;
   logic [7:0]       sh_tx, sh_rx, frame_b;
   logic [DIV_W-1:0] sh_div;

   spicmd_framer u_framer (
      .opcode (op_q),
      .arg    (arg_q),
      .idx    (idx[2:0]),
      .byte_o (frame_b)
   );

   assign sh_go  = (st != S_IDLE) && !sh_active && !sh_done;
   assign sh_tx  = (st == S_FRAME) ? frame_b : 8'hFF;
   assign sh_div = ((st == S_WAKE) || (op_q == OP_RESET)) ? DIV_SLOW : DIV_MED;

   spicmd_shifter #(.DIV_W(DIV_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (sh_go),
      .tx     (sh_tx),
      .div    (sh_div),
      .active (sh_active),
      .done   (sh_done),
      .rx     (sh_rx),
      .sclk   (sclk),
      .mosi   (mosi),
      .miso   (miso)
   );

   assign busy = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         idx      <= '0;
         poll_cnt <= '0;
         ext_left <= '0;
         op_q     <= '0;
         arg_q    <= '0;
         typ_q    <= '0;
         done     <= 1'b0;
         status   <= ST_OK;
         resp     <= '0;
         resp_ext <= '0;
         cs_n     <= 1'b1;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  idx    <= '0;
                  status <= ST_OK;
                  if (init) begin
                     st   <= S_WAKE;
                     cs_n <= 1'b1;
                  end else begin
                     st       <= S_FRAME;
                     cs_n     <= 1'b0;
                     op_q     <= opcode;
                     arg_q    <= arg;
                     typ_q    <= rsp_type;
                     resp     <= '0;
                     resp_ext <= '0;
                  end
               end
            end
            S_WAKE: begin
               if (sh_done) begin
                  if (idx == WAKE_LAST) begin
                     st     <= S_IDLE;
                     cs_n   <= 1'b0;
                     status <= ST_OK;
                     done   <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            S_FRAME: begin
               if (sh_done) begin
                  if (idx == IC_W'(7)) begin
                     st       <= S_POLL;
                     poll_cnt <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            S_POLL: begin
               if (sh_done) begin
                  if (!sh_rx[7]) begin
                     resp <= {8'h00, sh_rx};
                     if (typ_q == RT_WIDE) begin
                        st       <= S_EXTRA;
                        ext_left <= 3'd1;
                     end else if (typ_q == RT_LONG) begin
                        st       <= S_EXTRA;
                        ext_left <= 3'd4;
                     end else begin
                        st     <= S_IDLE;
                        done   <= 1'b1;
                        status <= reply_ok(sh_rx) ? ST_OK : ST_IOERR;
                     end
                  end else if (poll_cnt == POLL_LAST) begin
                     st     <= S_IDLE;
                     done   <= 1'b1;
                     status <= ST_TIMEOUT;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                  end
               end
            end
            S_EXTRA: begin
               if (sh_done) begin
                  if (typ_q == RT_WIDE)
                     resp[15:8] <= sh_rx;
                  else
                     resp_ext <= {resp_ext[23:0], sh_rx};
                  ext_left <= ext_left - 3'd1;
                  if (ext_left == 3'd1) begin
                     st     <= S_IDLE;
                     done   <= 1'b1;
                     status <= reply_ok(resp[7:0]) ? ST_OK : ST_IOERR;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R1: chip-select low while the frame goes out
   a_r1_cs_low_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FRAME) |-> !cs_n);

   // R9: chip-select released through the wake-up sequence
   a_r9_cs_high_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAKE) |-> cs_n);

   // R4: while polling, the shifter only ever transmits ones
   a_r4_poll_mosi_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_POLL) && sh_active) |-> mosi);

   // R5: poll counter stays inside the limit
   a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_POLL) |-> (poll_cnt < PC_W'(POLL_LIMIT)));

   // R10: done is a single pulse with the engine idle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8: reserved status code never reported
   a_r8_status_code: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 2'd3));

endmodule

// File: tb/spicmd_engine_bench.sv
`timescale 1ns/1ps
module spicmd_engine_bench;

   localparam int SLOW = 4;
   localparam int MED  = 2;
   localparam int PLIM = 12;
   localparam int NINIT = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, init = 1'b0;
   logic [5:0]  opcode = '0;
   logic [31:0] arg = '0;
   logic [1:0]  rsp_type = '0;
   logic busy, done, sclk, mosi, cs_n;
   logic [1:0]  status;
   logic [15:0] resp;
   logic [31:0] resp_ext;
   logic miso_r = 1'b1;

   always #2.5 clk = ~clk;

   spicmd_engine #(
      .DIV_W(8), .SLOW_DIV(SLOW), .MED_DIV(MED),
      .POLL_LIMIT(PLIM), .INIT_BYTES(NINIT)
   ) u_spicmd_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .init(init),
      .opcode(opcode), .arg(arg), .rsp_type(rsp_type),
      .busy(busy), .done(done), .status(status), .resp(resp),
      .resp_ext(resp_ext), .sclk(sclk), .mosi(mosi), .miso(miso_r),
      .cs_n(cs_n)
   );

   int checks = 0;
   int errors = 0;

   // card model
   logic [7:0] q [0:63];
   int qn = 0, qi = 0;
   logic [7:0] cur = 8'hFF;
   int bc = 0;
   logic [7:0] rxs = 8'h00;
   logic [7:0] cap [0:255];
   int ncap = 0, ncap_hi = 0;
   realtime last_rise = 0;
   realtime pmin = 0, pmax = 0;

   always @(posedge sclk) begin
      if (bc != 0) begin
         if (pmin == 0 || ($realtime - last_rise) < pmin) pmin = $realtime - last_rise;
         if (($realtime - last_rise) > pmax) pmax = $realtime - last_rise;
      end
      last_rise = $realtime;
      rxs = {rxs[6:0], mosi};
      bc = bc + 1;
   end

   always @(negedge sclk) begin
      if (bc == 8) begin
         if (ncap < 256) cap[ncap] = rxs;
         ncap = ncap + 1;
         if (cs_n) ncap_hi = ncap_hi + 1;
         bc = 0;
         cur = (qi < qn) ? q[qi] : 8'hFF;
         qi = qi + 1;
         miso_r = cur[7];
      end else begin
         miso_r = cur[7-bc];
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qclear();
      qn = 0;
      ncap = 0; ncap_hi = 0; pmin = 0; pmax = 0;
   endtask

   task automatic qpush(input logic [7:0] b);
      if (qn < 64) begin q[qn] = b; qn++; end
   endtask

   task automatic qarm();
      cur = (qn > 0) ? q[0] : 8'hFF;
      qi = 1; bc = 0; miso_r = cur[7];
   endtask

   // 8 frame-time bytes of 0x00 (must be ignored), then fillers, then reply
   task automatic prep(input int nfill, input logic [7:0] fill);
      qclear();
      for (int i = 0; i < 8; i++) qpush(8'h00);
      for (int i = 0; i < nfill; i++) qpush(fill);
   endtask

   task automatic wait_done();
      int n = 0;
      @(negedge clk);
      while (!done && n < 20000) begin @(negedge clk); n++; end
      chk(done, "R10 done seen", done, 1);
   endtask

   task automatic issue(input bit ini, input logic [5:0] op, input logic [31:0] a, input logic [1:0] t);
      qarm();
      @(negedge clk);
      init = ini; opcode = op; arg = a; rsp_type = t; start = 1'b1;
      @(negedge clk);
      start = 1'b0; init = 1'b0;
      chk(busy, "R10 busy after start", busy, 1);
      wait_done();
   endtask

   function automatic logic [7:0] exp_frame(input logic [5:0] op, input logic [31:0] a, input int i);
      case (i)
         0: return 8'hFF;
         1: return 8'h40 | {2'b00, op};
         2: return a[31:24];
         3: return a[23:16];
         4: return a[15:8];
         5: return a[7:0];
         6: return (op == 0) ? 8'h95 : (op == 8) ? 8'h87 : 8'h00;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic chk_frame(input logic [5:0] op, input logic [31:0] a, input string req);
      bit ok = 1;
      int bad = 0;
      for (int i = 0; i < 8; i++)
         if (cap[i] !== exp_frame(op, a, i)) begin ok = 0; bad = i; end
      chk(ok, req, cap[bad], exp_frame(op, a, bad));
   endtask

   task automatic chk_period(input int div, input string req);
      chk((pmin == (div+1)*5.0) && (pmax == (div+1)*5.0), req, longint'(pmax), (div+1)*5);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] a;
      bit ok;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && status == 0, "R11 busy/done/status", {busy, done, status}, 0);
      chk(cs_n && !sclk && mosi, "R11 cs_n/sclk/mosi", {cs_n, sclk, mosi}, 3'b101);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n && !busy, "R11 after reset release", {cs_n, busy}, 2'b10);

      // R9 wake-up sequence
      qclear();
      issue(1'b1, 6'd0, 32'h0, 2'd0);
      chk(ncap == NINIT, "R9 wake byte count", ncap, NINIT);
      chk(ncap_hi == NINIT, "R9 bytes with cs high", ncap_hi, NINIT);
      ok = 1;
      for (int i = 0; i < NINIT; i++) if (cap[i] != 8'hFF) ok = 0;
      chk(ok, "R9 wake bytes all ones", ok, 1);
      chk(!cs_n && status == 0, "R9 cs low and ok after wake", {cs_n, status}, 0);
      chk_period(SLOW, "R3 wake uses slow divider");

      // R1 R2 R3 reset opcode, short reply 0x01 after 2 fillers
      prep(2, 8'hFF); qpush(8'h01);
      issue(1'b0, 6'd0, 32'h0, 2'd0);
      chk_frame(6'd0, 32'h0, "R2 opcode 0 frame");
      chk_period(SLOW, "R3 opcode 0 slow divider");
      chk(status == 0 && resp == 16'h0001, "R8 idle reply ok", {status, resp}, 16'h0001);
      chk(ncap_hi == 0, "R1 cs low during command", ncap_hi, 0);
      ok = 1;
      for (int i = 8; i < ncap; i++) if (cap[i] != 8'hFF) ok = 0;
      chk(ok && ncap == 11, "R4 poll bytes are 0xFF", ncap, 11);

      // R7 long reply on opcode 8
      prep(1, 8'hC3); qpush(8'h01); qpush(8'h00); qpush(8'h00); qpush(8'h01); qpush(8'hAA);
      issue(1'b0, 6'd8, 32'h000001AA, 2'd2);
      chk_frame(6'd8, 32'h000001AA, "R2 opcode 8 frame");
      chk_period(MED, "R3 opcode 8 medium divider");
      chk(resp_ext == 32'h000001AA, "R7 extended word", resp_ext, 32'h000001AA);
      chk(status == 0 && resp == 16'h0001, "R7 first byte and status", {status, resp}, 16'h0001);

      // R6 wide reply
      prep(0, 8'hFF); qpush(8'h00); qpush(8'h5A);
      issue(1'b0, 6'd17, 32'h12345678, 2'd1);
      chk_frame(6'd17, 32'h12345678, "R1 argument order");
      chk(resp == 16'h5A00 && status == 0, "R6 wide reply", resp, 16'h5A00);

      // R8 error reply, also through long format
      prep(3, 8'h80); qpush(8'h05);
      issue(1'b0, 6'd63, 32'hFFFFFFFF, 2'd0);
      chk_frame(6'd63, 32'hFFFFFFFF, "R1 opcode 63 frame");
      chk(status == 2 && resp == 16'h0005, "R8 error reply", {status, resp}, {2'd2, 16'h0005});
      prep(0, 8'hFF); qpush(8'h04); qpush(8'h11); qpush(8'h22); qpush(8'h33); qpush(8'h44);
      issue(1'b0, 6'd58, 32'h0, 2'd2);
      chk(status == 2 && resp_ext == 32'h11223344, "R8 error with long reply", resp_ext, 32'h11223344);

      // R5 timeout boundary
      prep(PLIM-1, 8'hFF); qpush(8'h00);
      issue(1'b0, 6'd1, 32'h0, 2'd0);
      chk(status == 0 && ncap == 8+PLIM, "R5 reply on last allowed poll", {status, 8'(ncap)}, 8+PLIM);
      prep(PLIM, 8'hFF); qpush(8'h00);
      issue(1'b0, 6'd1, 32'h0, 2'd0);
      chk(status == 1, "R5 timeout status", status, 1);
      chk(ncap == 8+PLIM, "R5 timeout byte count", ncap, 8+PLIM);

      // R10 start while busy ignored
      prep(1, 8'hFF); qpush(8'h00);
      qarm();
      @(negedge clk);
      opcode = 6'd9; arg = 32'hA5A5_0F0F; rsp_type = 2'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      opcode = 6'd5; arg = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk_frame(6'd9, 32'hA5A5_0F0F, "R10 busy start kept first frame");
      repeat (60) @(negedge clk);
      chk(!busy && ncap == 10, "R10 no second command", ncap, 10);

      // R1 R2 R3 opcode sweep
      for (int op = 0; op < 64; op++) begin
         a = {op[7:0] ^ 8'h3C, 8'h81 + op[7:0], 8'hE7, op[7:0]};
         prep(0, 8'hFF); qpush(8'h00);
         issue(1'b0, 6'(op), a, 2'd0);
         chk_frame(6'(op), a, "R2 sweep frame");
         chk_period((op == 0) ? SLOW : MED, "R3 sweep divider");
      end

      // R8 first-byte sweep
      for (int v = 0; v < 128; v++) begin
         prep(v % 3, 8'hFF); qpush(8'(v));
         issue(1'b0, 6'd13, 32'h0, 2'd0);
         chk(status == ((v <= 1) ? 2'd0 : 2'd2) && resp == 16'(v),
             "R8 sweep status", {status, resp}, {((v <= 1) ? 2'd0 : 2'd2), 16'(v)});
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule